// File: doc/BRIEF.md
# Halfword Instruction Prefetch Buffer

This block sits between a processor's instruction-fetch port and a 32-bit external memory read path. When the processor executes 16-bit compressed instructions and the external bus is 32 bits wide, every external word read brings in two instructions. The block hands the addressed halfword to the processor in the same cycle as the memory acknowledge. It parks the other halfword, tagged with its word address and lane, in a local register. A following fetch of that parked halfword is answered from the register in the same cycle, without any external access.

In every other combination of instruction mode and bus width the block is transparent. Each fetch is forwarded to the bus unchanged, the full read word is returned, and the buffer stays empty. A data write, leaving the buffered configuration, or reset all discard the parked halfword.

Top module: `hwfb_top`

## Requirements
- R1: After reset the buffer is empty, so the first fetch in buffered mode raises `mem_req`.
- R2: Buffering is active only when `mode_compact` and `bus_wide` are both 1. Otherwise `mem_req` follows `fetch_req`, `mem_addr` equals `fetch_addr`, and `fetch_rdata` equals `mem_rdata`.
- R3: In buffered mode a miss raises `mem_req` in the same cycle with a word-aligned `mem_addr` (bits 1:0 cleared). On `mem_ack`, `fetch_valid` is 1 in that same cycle and `fetch_rdata` carries the addressed halfword zero-extended. Address bit 1 = 0 selects bits 15:0 and bit 1 = 1 selects bits 31:16 (little-endian default).
- R4: On a buffered-mode fill, the other halfword of the word is stored. A fetch of that halfword's address is then answered in the same cycle with `fetch_valid` = 1 and `mem_req` = 0.
- R5: A fetch hits only when the stored word address and the halfword lane both match. A different word, or the lane that was forwarded rather than stored, goes to the bus.
- R6: `data_wr` = 1 discards the buffer. A fetch in the same cycle as `data_wr` is not served from the buffer and does not fill it.
- R7: Any cycle with buffering inactive discards the buffer. After buffering becomes active again, the first fetch goes to the bus.
- R8: A hit leaves the buffer unchanged, so a repeated fetch of the same stored halfword hits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Instruction fetch request, held until `fetch_valid` |
| fetch_addr | input | AW | Fetch byte address |
| mode_compact | input | 1 | Processor is in 16-bit instruction mode |
| bus_wide | input | 1 | External bus is in 32-bit mode |
| data_wr | input | 1 | A data write occurs this cycle |
| fetch_valid | output | 1 | Fetch data is valid this cycle |
| fetch_rdata | output | WW | Fetch data to the processor |
| mem_req | output | 1 | External word read request |
| mem_addr | output | AW | External read address |
| mem_ack | input | 1 | External read data valid |
| mem_rdata | input | WW | External read data |

## Verification
Every result of this block falls in the cycle of its stimulus. `mem_req`, `mem_addr`, `fetch_valid` and `fetch_rdata` are combinational from the fetch inputs, the memory acknowledge and the buffer state. The buffer itself changes only at the clock edge that closes a fill, a write or a cycle with buffering inactive. The bench drives each fetch at the falling edge and answers the bus in the same cycle through a combinational memory model. It samples all outputs one nanosecond later, before the next rising edge. Effects on the buffer are therefore always seen in the following fetch.

// File: rtl/hwfb_pkg.sv
package hwfb_pkg;
   // lane index inside a fetched word
   typedef enum logic {LANE_LO = 1'b0, LANE_HI = 1'b1} lane_e;

   function automatic int unsigned offset_bits(input int unsigned word_bits);
      return $clog2(word_bits / 8);
   endfunction
endpackage

// File: rtl/hwfb_lane_sel.sv
module hwfb_lane_sel #(
   parameter int unsigned WW         = 32,
   parameter bit          BIG_ENDIAN = 1'b0,
   localparam int unsigned HW        = WW / 2
) (
   input  logic [WW-1:0] word_in,
   input  logic          lane_bit,
   output logic [HW-1:0] want_half,
   output logic [HW-1:0] keep_half
);
   logic phys_hi;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign phys_hi = ~lane_bit;
      end else begin : g_little
         assign phys_hi = lane_bit;
      end
   endgenerate

   assign want_half = phys_hi ? word_in[WW-1:HW] : word_in[HW-1:0];
   assign keep_half = phys_hi ? word_in[HW-1:0]  : word_in[WW-1:HW];
endmodule

// File: rtl/hwfb_store.sv
module hwfb_store #(
   parameter int unsigned TW = 30,
   parameter int unsigned HW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [TW-1:0] load_tag,
   input  hwfb_pkg::lane_e load_lane,
   input  logic [HW-1:0] load_data,
   output logic          valid,
   output logic [TW-1:0] tag,
   output hwfb_pkg::lane_e lane,
   output logic [HW-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         tag   <= '0;
         lane  <= hwfb_pkg::LANE_LO;
         data  <= '0;
      end else if (clr) begin
         valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         tag   <= load_tag;
         lane  <= load_lane;
         data  <= load_data;
      end
   end

   assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !valid);
endmodule

// File: rtl/hwfb_top.sv
module hwfb_top #(
   parameter int unsigned AW         = 32,
   parameter int unsigned WW         = 32,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_req,
   input  logic [AW-1:0] fetch_addr,
   input  logic          mode_compact,
   input  logic          bus_wide,
   input  logic          data_wr,
   output logic          fetch_valid,
   output logic [WW-1:0] fetch_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [WW-1:0] mem_rdata
);
   localparam int unsigned HW   = WW / 2;
   localparam int unsigned OFFW = hwfb_pkg::offset_bits(WW);
   localparam int unsigned TW   = AW - OFFW;

   initial begin
      assert (WW >= 16 && WW % 16 == 0) else $error("WW must be a multiple of 16");
      assert (AW > OFFW) else $error("AW too small for WW");
   end

   logic            en, hit, fill;
   logic [TW-1:0]   word_tag;
   logic            lane_bit;
   logic [HW-1:0]   want_half, keep_half;
   logic            b_valid;
   logic [TW-1:0]   b_tag;
   hwfb_pkg::lane_e b_lane;
   logic [HW-1:0]   b_data;

   assign en       = mode_compact & bus_wide;
   assign word_tag = fetch_addr[AW-1:OFFW];
   assign lane_bit = fetch_addr[OFFW-1];

   hwfb_lane_sel #(.WW(WW), .BIG_ENDIAN(BIG_ENDIAN)) u_sel (
      .word_in   (mem_rdata),
      .lane_bit  (lane_bit),
      .want_half (want_half),
      .keep_half (keep_half)
   );

   assign hit = en & fetch_req & ~data_wr & b_valid
              & (b_tag == word_tag) & (b_lane == hwfb_pkg::lane_e'(lane_bit));

   assign mem_req     = fetch_req & ~hit;
   assign mem_addr    = en ? {word_tag, {OFFW{1'b0}}} : fetch_addr;
   assign fetch_valid = hit | (mem_req & mem_ack);
   assign fill        = en & mem_req & mem_ack & ~data_wr;

   always_comb begin
      if (hit)     fetch_rdata = {{(WW-HW){1'b0}}, b_data};
      else if (en) fetch_rdata = {{(WW-HW){1'b0}}, want_half};
      else         fetch_rdata = mem_rdata;
   end

   hwfb_store #(.TW(TW), .HW(HW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (~en | data_wr),
      .load      (fill),
      .load_tag  (word_tag),
      .load_lane (hwfb_pkg::lane_e'(~lane_bit)),
      .load_data (keep_half),
      .valid     (b_valid),
      .tag       (b_tag),
      .lane      (b_lane),
      .data      (b_data)
   );

   assert_inactive_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !b_valid);
   assert_passthrough_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !en) |-> mem_req);
   assert_busless_needs_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !mem_req) |-> (en && b_valid));
endmodule

// File: tb/sim_hwfb_top.sv
module sim_hwfb_top;
   localparam int AW = 32;
   localparam int WW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          mode_compact = 1'b0;
   logic          bus_wide = 1'b0;
   logic          data_wr = 1'b0;
   logic          fetch_valid;
   logic [WW-1:0] fetch_rdata;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ack;
   logic [WW-1:0] mem_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   // memory model: answers in the same cycle, content derived from word address
   assign mem_ack   = mem_req;
   assign mem_rdata = {4'hB, mem_addr[13:2], 4'hA, mem_addr[13:2]};

   hwfb_top #(.AW(AW), .WW(WW)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .mode_compact(mode_compact), .bus_wide(bus_wide), .data_wr(data_wr),
      .fetch_valid(fetch_valid), .fetch_rdata(fetch_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one fetch cycle: drive at falling edge, sample 1 ns later
   task automatic fetch(input logic c, input logic b, input logic w, input logic [15:0] a,
                        input logic exp_mreq, input logic [31:0] exp_data, input string req);
      @(negedge clk);
      mode_compact = c; bus_wide = b; data_wr = w;
      fetch_req = 1'b1; fetch_addr = {16'h0, a};
      #1;
      check({req, " mem_req"}, 64'(mem_req), 64'(exp_mreq));
      check({req, " fetch_valid"}, 64'(fetch_valid), 64'd1);
      check({req, " fetch_rdata"}, 64'(fetch_rdata), 64'(exp_data));
      @(posedge clk);
      #0.5;
      fetch_req = 1'b0; data_wr = 1'b0;
   endtask

   // vector: compact, wide, addr, expected mem_req, expected data
   typedef logic [50:0] vec_t;
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      {1'b1, 1'b1, 16'h0100, 1'b1, 32'h0000A040},  // R1 R3 first fill, low lane
      {1'b1, 1'b1, 16'h0102, 1'b0, 32'h0000B040},  // R4 hit on stored upper lane
      {1'b1, 1'b1, 16'h0102, 1'b0, 32'h0000B040},  // R8 repeated hit
      {1'b1, 1'b1, 16'h0100, 1'b1, 32'h0000A040},  // R5 forwarded lane misses
      {1'b1, 1'b1, 16'h0106, 1'b1, 32'h0000B041},  // R5 other word misses, R3 high lane
      {1'b1, 1'b1, 16'h0104, 1'b0, 32'h0000A041},  // R4 hit on stored lower lane
      {1'b0, 1'b1, 16'h0104, 1'b1, 32'hB041A041},  // R2 not compact: full word
      {1'b1, 1'b1, 16'h0106, 1'b1, 32'h0000B041},  // R7 buffer lost while inactive
      {1'b1, 1'b0, 16'h0104, 1'b1, 32'hB041A041},  // R2 narrow bus: full word
      {1'b1, 1'b1, 16'h0104, 1'b1, 32'h0000A041}   // R7 refetch after narrow bus
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset fetch_valid", 64'(fetch_valid), 64'd0);
      check("R1 reset mem_req", 64'(mem_req), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         fetch(v[50], v[49], 1'b0, v[48:33], v[32], v[31:0], $sformatf("vec%0d", i));
      end

      // R2 address passes through unchanged when inactive
      @(negedge clk);
      mode_compact = 1'b0; bus_wide = 1'b1; fetch_req = 1'b1; fetch_addr = 32'h0000_0302;
      #1;
      check("R2 mem_addr passthrough", 64'(mem_addr), 64'h302);
      @(posedge clk); #0.5; fetch_req = 1'b0;

      // R3 word-aligned address in buffered mode
      @(negedge clk);
      mode_compact = 1'b1; bus_wide = 1'b1; fetch_req = 1'b1; fetch_addr = 32'h0000_0302;
      #1;
      check("R3 mem_addr aligned", 64'(mem_addr), 64'h300);
      check("R3 upper lane data", 64'(fetch_rdata), 64'h0000B0C0);
      @(posedge clk); #0.5; fetch_req = 1'b0;
      // buffer now holds lower lane of word 0x300
      fetch(1'b1, 1'b1, 1'b0, 16'h0300, 1'b0, 32'h0000A0C0, "R4 hit lower lane");

      // R6 write alone discards buffer
      @(negedge clk); data_wr = 1'b1;
      @(posedge clk); #0.5; data_wr = 1'b0;
      fetch(1'b1, 1'b1, 1'b0, 16'h0300, 1'b1, 32'h0000A0C0, "R6 miss after write");

      // R6 write in same cycle as fetch: no hit, no fill
      fetch(1'b1, 1'b1, 1'b1, 16'h0302, 1'b1, 32'h0000B0C0, "R6 no hit with write");
      fetch(1'b1, 1'b1, 1'b0, 16'h0300, 1'b1, 32'h0000A0C0, "R6 no fill with write");
      fetch(1'b1, 1'b1, 1'b0, 16'h0302, 1'b0, 32'h0000B0C0, "R4 hit after clean fill");

      // R1 reset empties buffer
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      fetch(1'b1, 1'b1, 1'b0, 16'h0302, 1'b1, 32'h0000B0C0, "R1 miss after reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule